// File: doc/BRIEF.md
# Counter overflow interrupt controller

This block gathers single-cycle overflow pulses from two groups of event counters, sixteen general-purpose ones and eight bandwidth ones, into one 24-bit sticky status vector. Each status bit stays set once its source has pulsed, until software clears it. A per-source enable mask decides which status bits may raise the single level-sensitive interrupt line.

Software reaches the block over a simple 32-bit register bus. Writes commit on the clock edge and reads are combinational. The enable mask can only be changed through two write-one registers, one that sets bits and one that clears bits, so different owners can change their own sources without a read-modify-write. The mask and the status vector each have a read-only view. A separate write-one-to-clear register acknowledges status bits.

Top module: `ovf_irq_ctrl`

## Requirements
- R1: After reset the enable mask and the status vector are all zero and `irq_o` is low.
- R2: A one-cycle pulse on `ovf_common_i[i]` sets status bit 8+i, read at byte offset 0x0C, at the next clock edge.
- R3: A one-cycle pulse on `ovf_bw_i[j]` sets status bit j, read at byte offset 0x0C, at the next clock edge.
- R4: A status bit stays set until it is cleared, whether or not its enable bit is set.
- R5: A write to offset 0x00 sets every enable bit whose data bit is one and leaves the other enable bits unchanged.
- R6: A write to offset 0x04 clears every enable bit whose data bit is one and leaves the other enable bits unchanged.
- R7: Offset 0x08 reads the enable mask in bits 23:0, with bits 31:24 read as zero. Writing ones above bit 23 at offset 0x00 has no effect.
- R8: A write to offset 0x10 clears every status bit whose data bit is one. Writing 0xFFFFFF clears the whole vector.
- R9: If a source pulses in the same cycle that a clear write targets its status bit, the bit stays set.
- R10: `irq_o` is high exactly when some status bit and its enable bit are both set. It follows the registers in the same cycle.
- R11: Writes to offsets 0x08 and 0x0C change neither the enable mask nor the status vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ovf_common_i | input | 16 | Overflow pulses, general-purpose counters |
| ovf_bw_i | input | 8 | Overflow pulses, bandwidth counters |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that an overflow input is high for only one cycle per event and that at most one register write happens per cycle. They also assume that addresses are word aligned, so one write can never hit both enable registers. The stimulus pulses each source for exactly one clock, issues every write as a single-cycle strobe on an aligned offset, and changes inputs only on the falling edge. The only overlap between a pulse and a clear is the one that R9 calls for, where both land in the same cycle on purpose.

// File: rtl/ovf_irq_pkg.sv
`timescale 1ns/1ps
package ovf_irq_pkg;

   // Word index of each register (byte offset = index * 4)
   localparam int unsigned IDX_EN_SET  = 0;
   localparam int unsigned IDX_EN_CLR  = 1;
   localparam int unsigned IDX_EN_STAT = 2;
   localparam int unsigned IDX_STATUS  = 3;
   localparam int unsigned IDX_ST_CLR  = 4;

   typedef enum logic [2:0] {
      RSEL_NONE    = 3'd0,
      RSEL_EN_SET  = 3'd1,
      RSEL_EN_CLR  = 3'd2,
      RSEL_EN_STAT = 3'd3,
      RSEL_STATUS  = 3'd4,
      RSEL_ST_CLR  = 3'd5
   } reg_sel_e;

endpackage

// File: rtl/ovf_irq_regif.sv
`timescale 1ns/1ps
module ovf_irq_regif
   import ovf_irq_pkg::*;
#(
   parameter int unsigned NSRC   = 24,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [NSRC-1:0]   mask_i,
   input  logic [NSRC-1:0]   status_i,
   output logic [NSRC-1:0]   en_set_o,
   output logic [NSRC-1:0]   en_clr_o,
   output logic [NSRC-1:0]   st_clr_o,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int unsigned IDX_W = ADDR_W - 2;

   localparam logic [IDX_W-1:0] A_EN_SET  = IDX_W'(IDX_EN_SET);
   localparam logic [IDX_W-1:0] A_EN_CLR  = IDX_W'(IDX_EN_CLR);
   localparam logic [IDX_W-1:0] A_EN_STAT = IDX_W'(IDX_EN_STAT);
   localparam logic [IDX_W-1:0] A_STATUS  = IDX_W'(IDX_STATUS);
   localparam logic [IDX_W-1:0] A_ST_CLR  = IDX_W'(IDX_ST_CLR);

   logic [IDX_W-1:0] idx;
   logic             aligned;
   reg_sel_e         sel;
   logic [NSRC-1:0]  wbits;

   assign idx     = addr_i[ADDR_W-1:2];
   assign aligned = (addr_i[1:0] == 2'b00);
   assign wbits   = wdata_i[NSRC-1:0];

   generate
      if (DATA_W > NSRC) begin : g_wide
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^wdata_i[DATA_W-1:NSRC];
      end
   endgenerate

   always_comb begin
      sel = RSEL_NONE;
      if (aligned) begin
         case (idx)
            A_EN_SET:  sel = RSEL_EN_SET;
            A_EN_CLR:  sel = RSEL_EN_CLR;
            A_EN_STAT: sel = RSEL_EN_STAT;
            A_STATUS:  sel = RSEL_STATUS;
            A_ST_CLR:  sel = RSEL_ST_CLR;
            default:   sel = RSEL_NONE;
         endcase
      end
   end

   always_comb begin
      en_set_o = '0;
      en_clr_o = '0;
      st_clr_o = '0;
      if (wr_en_i) begin
         unique case (sel)
            RSEL_EN_SET: en_set_o = wbits;
            RSEL_EN_CLR: en_clr_o = wbits;
            RSEL_ST_CLR: st_clr_o = wbits;
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata_o = '0;
      unique case (sel)
         RSEL_EN_STAT: rdata_o[NSRC-1:0] = mask_i;
         RSEL_STATUS:  rdata_o[NSRC-1:0] = status_i;
         default: ;
      endcase
   end

endmodule

// File: rtl/ovf_irq_mask.sv
`timescale 1ns/1ps
module ovf_irq_mask #(
   parameter int unsigned NSRC = 24
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_i,
   input  logic [NSRC-1:0] clr_i,
   output logic [NSRC-1:0] mask_o
);

   generate
      for (genvar b = 0; b < NSRC; b++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mask_o[b] <= 1'b0;
            else if (clr_i[b])
               mask_o[b] <= 1'b0;
            else if (set_i[b])
               mask_o[b] <= 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/ovf_irq_status.sv
`timescale 1ns/1ps
module ovf_irq_status #(
   parameter int unsigned NSRC = 24
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] pulse_i,
   input  logic [NSRC-1:0] clr_i,
   output logic [NSRC-1:0] status_o
);

   generate
      for (genvar b = 0; b < NSRC; b++) begin : g_bit
         // a fresh event outranks the acknowledge in the same cycle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               status_o[b] <= 1'b0;
            else if (pulse_i[b])
               status_o[b] <= 1'b1;
            else if (clr_i[b])
               status_o[b] <= 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/ovf_irq_ctrl.sv
`timescale 1ns/1ps
module ovf_irq_ctrl
   import ovf_irq_pkg::*;
#(
   parameter int unsigned NUM_COMMON = 16,
   parameter int unsigned NUM_BW     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 8,
   parameter bit          IRQ_REG    = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_COMMON-1:0] ovf_common_i,
   input  logic [NUM_BW-1:0]     ovf_bw_i,
   input  logic                  reg_wr_en_i,
   input  logic [ADDR_W-1:0]     reg_addr_i,
   input  logic [DATA_W-1:0]     reg_wdata_i,
   output logic [DATA_W-1:0]     reg_rdata_o,
   output logic                  irq_o
);

   localparam int unsigned NSRC = NUM_COMMON + NUM_BW;

   generate
      if (NUM_COMMON < 1 || NUM_BW < 1) begin : g_bad_groups
         $error("ovf_irq_ctrl: both counter groups need at least one source");
      end
      if (NSRC > DATA_W) begin : g_bad_width
         $error("ovf_irq_ctrl: sources do not fit in the data word");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ovf_irq_ctrl: address too narrow for five registers");
      end
   endgenerate

   logic [NSRC-1:0] src_pulse;
   logic [NSRC-1:0] en_set;
   logic [NSRC-1:0] en_clr;
   logic [NSRC-1:0] st_clr;
   logic [NSRC-1:0] mask_q;
   logic [NSRC-1:0] status_q;
   logic            irq_any;

   // bandwidth group in the low field, general-purpose group above it
   assign src_pulse = {ovf_common_i, ovf_bw_i};

   ovf_irq_regif #(
      .NSRC   (NSRC),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) regif_i (
      .wr_en_i  (reg_wr_en_i),
      .addr_i   (reg_addr_i),
      .wdata_i  (reg_wdata_i),
      .mask_i   (mask_q),
      .status_i (status_q),
      .en_set_o (en_set),
      .en_clr_o (en_clr),
      .st_clr_o (st_clr),
      .rdata_o  (reg_rdata_o)
   );

   ovf_irq_mask #(
      .NSRC (NSRC)
   ) mask_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (en_set),
      .clr_i  (en_clr),
      .mask_o (mask_q)
   );

   ovf_irq_status #(
      .NSRC (NSRC)
   ) status_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pulse_i  (src_pulse),
      .clr_i    (st_clr),
      .status_o (status_q)
   );

   assign irq_any = |(status_q & mask_q);

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_any;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = irq_any;
      end
   endgenerate

endmodule

// File: rtl/ovf_irq_ctrl_chk.sv
`timescale 1ns/1ps
module ovf_irq_ctrl_chk
   import ovf_irq_pkg::*;
#(
   parameter int unsigned NSRC    = 24,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NSRC-1:0]   src_pulse,
   input logic              reg_wr_en_i,
   input logic [ADDR_W-1:0] reg_addr_i,
   input logic [DATA_W-1:0] reg_wdata_i,
   input logic [NSRC-1:0]   mask_q,
   input logic [NSRC-1:0]   status_q,
   input logic              irq_o
);

   logic            w_set, w_clr, w_ack;
   logic [NSRC-1:0] wb;
   logic            unused_chk;

   assign w_set = reg_wr_en_i && (reg_addr_i == ADDR_W'(IDX_EN_SET * 4));
   assign w_clr = reg_wr_en_i && (reg_addr_i == ADDR_W'(IDX_EN_CLR * 4));
   assign w_ack = reg_wr_en_i && (reg_addr_i == ADDR_W'(IDX_ST_CLR * 4));
   assign wb    = reg_wdata_i[NSRC-1:0];
   assign unused_chk = ^reg_wdata_i;

   // R2 R3: a pulse is captured at the next edge
   p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & $past(src_pulse)) == $past(src_pulse)));

   // R4: set bits survive unless acknowledged
   p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & $past(status_q & ~(w_ack ? wb : '0)))
                == $past(status_q & ~(w_ack ? wb : '0))));

   // R5
   p_enset_r5: assert property (@(posedge clk) disable iff (!rst_n)
      w_set |=> ((mask_q & $past(wb)) == $past(wb)));

   // R6
   p_enclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      w_clr |=> ((mask_q & $past(wb)) == '0));

   // R11: mask moves only through its two write registers
   p_mask_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(w_set || w_clr) |=> $stable(mask_q));

   generate
      if (IRQ_REG) begin : g_reg
         p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o |-> $past((status_q & mask_q) != '0));
      end else begin : g_comb
         p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o |-> ((status_q != '0) && (mask_q != '0)));
      end
   endgenerate

endmodule

bind ovf_irq_ctrl ovf_irq_ctrl_chk #(
   .NSRC    (NUM_COMMON + NUM_BW),
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .IRQ_REG (IRQ_REG)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .src_pulse   (src_pulse),
   .reg_wr_en_i (reg_wr_en_i),
   .reg_addr_i  (reg_addr_i),
   .reg_wdata_i (reg_wdata_i),
   .mask_q      (mask_q),
   .status_q    (status_q),
   .irq_o       (irq_o)
);

// File: tb/ovf_irq_ctrl_tb.sv
`timescale 1ns/1ps
module ovf_irq_ctrl_tb_top;

   localparam int NC = 16;
   localparam int NB = 8;
   localparam int NS = NC + NB;

   localparam logic [7:0] A_SET  = 8'h00;
   localparam logic [7:0] A_CLR  = 8'h04;
   localparam logic [7:0] A_EST  = 8'h08;
   localparam logic [7:0] A_STS  = 8'h0C;
   localparam logic [7:0] A_ACK  = 8'h10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NC-1:0] ovf_common = '0;
   logic [NB-1:0] ovf_bw = '0;
   logic          wr_en = 1'b0;
   logic [7:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          irq;

   int n_vec = 0;
   int n_bad = 0;
   logic [NS-1:0] exp_st = '0;
   logic [NS-1:0] exp_mk = '0;

   always #4 clk = ~clk;

   ovf_irq_ctrl dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .ovf_common_i (ovf_common),
      .ovf_bw_i     (ovf_bw),
      .reg_wr_en_i  (wr_en),
      .reg_addr_i   (addr),
      .reg_wdata_i  (wdata),
      .reg_rdata_o  (rdata),
      .irq_o        (irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one clock: drive at negedge, edge captures, return at next negedge idle
   task automatic step(input logic [NS-1:0] src, input logic we,
                       input logic [7:0] a, input logic [31:0] d);
      {ovf_common, ovf_bw} = src;
      wr_en = we; addr = a; wdata = d;
      @(negedge clk);
      {ovf_common, ovf_bw} = '0;
      wr_en = 1'b0; addr = '0; wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1 d = rdata;
      addr = '0;
   endtask

   task automatic check_all(input string req);
      logic [31:0] v;
      rd(A_STS, v);
      chk({req, " status"}, v, {8'h0, exp_st});
      rd(A_EST, v);
      chk({req, " mask"}, v, {8'h0, exp_mk});
      chk({req, " irq"}, {31'b0, irq}, {31'b0, |(exp_st & exp_mk)});
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // per-source sweep
      for (int k = 0; k < NS; k++) begin
         logic [NS-1:0] one;
         one = NS'(1) << k;
         step(one, 1'b0, 8'h0, 32'h0);
         exp_st = one;
         check_all(k >= NB ? "R2" : "R3");
         repeat (3) @(negedge clk);
         check_all("R4");
         step('0, 1'b1, A_SET, 32'(one));
         exp_mk = one;
         check_all("R10");
         step('0, 1'b1, A_CLR, 32'(one));
         exp_mk = '0;
         check_all("R6");
         step('0, 1'b1, A_ACK, 32'(one));
         exp_st = '0;
         check_all("R8");
      end

      // set/clear accumulate
      step('0, 1'b1, A_SET, 32'h00F0F0); exp_mk = 24'h00F0F0; check_all("R5");
      step('0, 1'b1, A_SET, 32'h0F0000); exp_mk = 24'h0FF0F0; check_all("R5");
      step('0, 1'b1, A_CLR, 32'h000FF0); exp_mk = 24'h0FF000; check_all("R6");
      step('0, 1'b1, A_SET, 32'hFFFFFFFF); exp_mk = 24'hFFFFFF; check_all("R7");
      step('0, 1'b1, A_CLR, 32'hFFFFFFFF); exp_mk = '0; check_all("R6");

      // read-only offsets
      step('0, 1'b1, A_SET, 32'h000123); exp_mk = 24'h000123;
      step('0, 1'b1, A_STS, 32'hFFFFFFFF); check_all("R11");
      step('0, 1'b1, A_EST, 32'h00000000); check_all("R11");
      rd(A_ACK, v); chk("R7 ack reads zero", v, 32'h0);

      // status without matching enable: no interrupt
      step(24'h000010, 1'b0, 8'h0, 32'h0); exp_st = 24'h000010; check_all("R10");
      step('0, 1'b1, A_SET, 32'h000010); exp_mk = 24'h000133; check_all("R10");

      // simultaneous pulse and acknowledge
      step(24'h000200, 1'b0, 8'h0, 32'h0); exp_st = 24'h000210;
      step(24'h000020, 1'b1, A_ACK, 32'h000230);
      exp_st = 24'h000020; check_all("R9");

      // all sources together, full clear
      step('1, 1'b0, 8'h0, 32'h0); exp_st = '1; check_all("R2");
      step('0, 1'b1, A_ACK, 32'h00FFFFFF); exp_st = '0; check_all("R8");

      // mid-run reset
      step(24'h800001, 1'b0, 8'h0, 32'h0);
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
      exp_st = '0; exp_mk = '0; check_all("R1");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule